// File: doc/BRIEF.md
# Serial ADC Frame Interface Port

This block is the device-side serial port of a multichannel sampling converter. A host drives an active-low chip-select, a serial clock that idles high, and a serial data input. The block returns a three-state serial data output, given here as a data bit plus an output-enable for the pad. Each frame is sixteen serial clocks long. During a frame the block shifts out a channel-tagged conversion result and shifts in a 16-bit control word. It also drives a hold/track strobe to the sampling front end.

The serial pins are brought into the block's system clock domain through a synchronizer and are edge-detected there. The host's serial clock must therefore be much slower than the system clock. When chip-select falls, the block copies the conversion source's 4-bit channel tag and 10-bit result into an output shift register. It then drives the first bit at once and launches each later bit on a serial-clock falling edge. The control register is written only when a full frame completes and the first bit received was a 1.

Top module: `serial_adc_port`

## Requirements
- R1: After reset, `sdo_oe`, `sdo` and `sample_hold` are 0, and every configuration output (`cfg_repeat`, `cfg_chan_sel`, `cfg_ref_sel`, `cfg_pwr_down`) is 0.
- R2: A chip-select falling edge sets `sdo_oe` and `sample_hold` to 1 and drives the most significant tag bit on `sdo` before any serial-clock edge.
- R3: The output word is {tag[3:0], result[9:0], 2'b00}, sent most significant bit first. After k serial-clock falling edges (k = 0..15), `sdo` carries word bit 15-k.
- R4: `sample_hold` stays 1 through the thirteenth falling edge of a frame and returns to 0 on the fourteenth.
- R5: On the sixteenth falling edge `sdo_oe` returns to 0, and `sdo` reads 0 while disabled.
- R6: Raising chip-select after fewer than sixteen falling edges sets `sdo_oe` and `sample_hold` to 0 at once and leaves the configuration outputs unchanged.
- R7: `sdi` is captured on each of the first sixteen falling edges and forms the control word, whose bit 15 is received first. On a complete frame with word bit 15 (write flag) = 1, the outputs take: `cfg_repeat` = bit 14, `cfg_chan_sel[7:0]` = bits 13:6, `cfg_ref_sel` = bit 2, `cfg_pwr_down` = bit 0. Bits 5:3 and 1 are ignored.
- R8: A complete frame whose write flag is 0 leaves every configuration output unchanged.
- R9: Tag and result are taken at the chip-select falling edge, so changing `conv_tag` or `conv_result` during a frame does not alter the bits sent.
- R10: Every chip-select falling edge restarts the bit count, including right after an aborted frame, so the next frame sends its whole word from the tag's first bit.
- R11: Serial-clock falling edges after the sixteenth, or while chip-select is high, shift nothing. The output stays disabled and the committed configuration is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial clock, idles high |
| sdi | input | 1 | Serial control data from the host |
| sdo | output | 1 | Serial result data (0 when disabled) |
| sdo_oe | output | 1 | Output enable for the three-state pad |
| sample_hold | output | 1 | 1 = hold, 0 = track, to the sampler |
| conv_tag | input | 4 | Channel tag of the current conversion |
| conv_result | input | 10 | Current conversion result |
| cfg_repeat | output | 1 | Committed repeat flag |
| cfg_chan_sel | output | 8 | Committed channel-select bits |
| cfg_ref_sel | output | 1 | Committed reference-select bit |
| cfg_pwr_down | output | 1 | Committed power-down bit |

## Verification
The bench sweeps every tag against a set of result patterns. It checks every bit position, so a swapped bit order, a skipped first bit or nonzero padding shows up as a wrong bit at a known edge. It aborts a write frame after every count from zero to fifteen edges. A design that commits early, or that leaves the pad enabled after chip-select rises, is caught there, and so is one that fails to restart its count on the next frame. Further checks cover a write flag of 0, extra clocks after the sixteenth, clocks while deselected, and a source that changes mid-frame. These catch a control register that moves when it must not, and an output word that is not latched.

// File: rtl/sap_pkg.sv
// Shared constants and types for the serial ADC frame port.
// Assumes a 16-clock frame and a power-down bit in the last word position.
package sap_pkg;
    localparam int FRAME_LEN = 16;
    localparam int NUM_CH    = 8;
    localparam int CNT_W     = $clog2(FRAME_LEN + 1);

    // Control-word bit positions; bit FRAME_LEN-1 is received first.
    localparam int POS_WR    = 15;
    localparam int POS_RPT   = 14;
    localparam int POS_CH_HI = 13;
    localparam int POS_REF   = 2;
    localparam int POS_PD    = 0;

    typedef struct packed {
        logic              rpt;
        logic [NUM_CH-1:0] chan;
        logic              ref_sel;
        logic              pwr_dn;
    } cfg_fields_t;

    localparam int CFG_W = $bits(cfg_fields_t);
endpackage

// File: rtl/sap_in_sync.sv
// Multi-stage synchronizer for a vector of asynchronous serial pins.
// Assumes each pin is slow relative to clk; no cross-bit coherency implied.
module sap_in_sync #(
    parameter int          N       = 3,
    parameter int          STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage samples the raw pins.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= d;
                end
            end else begin : g_rest
                // Later stages settle metastability.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sap_frame_ctrl.sv
// Frame sequencer: detects select and clock edges, counts falling edges,
// and owns the output-enable and hold strobes. Assumes synchronized inputs.
module sap_frame_ctrl #(
    parameter int FRAME_LEN = 16,
    parameter int HOLD_EDGE = 14,
    localparam int CNT_W    = $clog2(FRAME_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_q,
    input  logic             sclk_q,
    output logic             frame_start,
    output logic             frame_stop,
    output logic             shift_en,
    output logic             last_edge,
    output logic [CNT_W-1:0] bit_cnt,
    output logic             drive_en,
    output logic             hold
);
    logic cs_prev;
    logic sclk_prev;
    logic active;
    logic sclk_fall;
    logic hold_edge;

    // Remember previous pin levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_prev   <= 1'b1;
            sclk_prev <= 1'b1;
        end else begin
            cs_prev   <= cs_q;
            sclk_prev <= sclk_q;
        end
    end

    // Edge decode and per-edge qualifiers.
    always_comb begin
        frame_start = cs_prev & ~cs_q;
        frame_stop  = ~cs_prev & cs_q;
        sclk_fall   = sclk_prev & ~sclk_q;
        shift_en    = sclk_fall & active & ~cs_q & ~frame_start
                      & (bit_cnt < CNT_W'(FRAME_LEN));
        last_edge   = shift_en & (bit_cnt == CNT_W'(FRAME_LEN - 1));
        hold_edge   = shift_en & (bit_cnt == CNT_W'(HOLD_EDGE - 1));
    end

    // Frame-active flag: set by select fall, cleared by select rise.
    always_ff @(posedge clk) begin
        if (!rst_n)           active <= 1'b0;
        else if (frame_start) active <= 1'b1;
        else if (frame_stop)  active <= 1'b0;
    end

    // Falling-edge counter, restarted on every frame start, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)           bit_cnt <= '0;
        else if (frame_start) bit_cnt <= '0;
        else if (shift_en)    bit_cnt <= bit_cnt + 1'b1;
    end

    // Pad enable: on at frame start, off after the final edge or an abort.
    always_ff @(posedge clk) begin
        if (!rst_n)                       drive_en <= 1'b0;
        else if (frame_start)             drive_en <= 1'b1;
        else if (frame_stop || last_edge) drive_en <= 1'b0;
    end

    // Sampler strobe: hold at frame start, track at the release edge or abort.
    always_ff @(posedge clk) begin
        if (!rst_n)                       hold <= 1'b0;
        else if (frame_start)             hold <= 1'b1;
        else if (frame_stop || hold_edge) hold <= 1'b0;
    end
endmodule

// File: rtl/sap_out_shift.sv
// Output shift register: captures tag, result and zero padding at frame
// start and moves one bit toward the MSB per qualified falling edge.
// Assumes TAG_W + RES_W <= FRAME_LEN.
module sap_out_shift #(
    parameter int TAG_W     = 4,
    parameter int RES_W     = 10,
    parameter int FRAME_LEN = 16,
    localparam int PAD_W    = FRAME_LEN - TAG_W - RES_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic             oe,
    input  logic [TAG_W-1:0] tag,
    input  logic [RES_W-1:0] res,
    output logic             sdo
);
    logic [FRAME_LEN-1:0] load_word;
    logic [FRAME_LEN-1:0] sr;

    generate
        if (PAD_W > 0) begin : g_pad
            assign load_word = {tag, res, {PAD_W{1'b0}}};
        end else begin : g_nopad
            assign load_word = {tag, res};
        end
    endgenerate

    // Load on frame start, shift toward the MSB on each counted edge.
    always_ff @(posedge clk) begin
        if (!rst_n)     sr <= '0;
        else if (load)  sr <= load_word;
        else if (shift) sr <= {sr[FRAME_LEN-2:0], 1'b0};
    end

    // Present the MSB only while the pad is enabled.
    assign sdo = oe & sr[FRAME_LEN-1];
endmodule

// File: rtl/sap_ctl_reg.sv
// Control-word receiver and configuration register. Holds the first
// FRAME_LEN-1 received bits; the last bit comes straight from sdi at commit.
// Assumes the power-down field sits in word bit 0.
module sap_ctl_reg
    import sap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        shift,
    input  logic        last_edge,
    input  logic        din,
    output cfg_fields_t cfg
);
    logic [FRAME_LEN-2:0] in_sr;
    logic                 wr_flag;

    // Word bit p (p >= 1) sits in in_sr[p-1] when the final bit arrives.
    assign wr_flag = in_sr[POS_WR-1];

    // Collect received bits during the frame.
    always_ff @(posedge clk) begin
        if (!rst_n)     in_sr <= '0;
        else if (start) in_sr <= '0;
        else if (shift) in_sr <= {in_sr[FRAME_LEN-3:0], din};
    end

    // Commit the fields only on a full frame whose write flag is set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (last_edge && wr_flag) begin
            cfg.rpt     <= in_sr[POS_RPT-1];
            cfg.chan    <= in_sr[POS_CH_HI-1 -: NUM_CH];
            cfg.ref_sel <= in_sr[POS_REF-1];
            cfg.pwr_dn  <= din;
        end
    end
endmodule

// File: rtl/serial_adc_port.sv
// Top of the serial ADC frame port. Synchronizes the host pins, sequences
// the frame, shifts the tagged result out and the control word in.
// Assumes the serial clock half-period exceeds SYNC_STAGES + 2 clk cycles.
module serial_adc_port
    import sap_pkg::*;
#(
    parameter int TAG_W       = 4,
    parameter int RES_W       = 10,
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_EDGE   = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              sample_hold,
    input  logic [TAG_W-1:0]  conv_tag,
    input  logic [RES_W-1:0]  conv_result,
    output logic              cfg_repeat,
    output logic [NUM_CH-1:0] cfg_chan_sel,
    output logic              cfg_ref_sel,
    output logic              cfg_pwr_down
);
    logic [2:0]       pins_q;
    logic             frame_start;
    logic             frame_stop;
    logic             shift_en;
    logic             last_edge;
    logic [CNT_W-1:0] bit_cnt;
    cfg_fields_t      cfg;

    sap_in_sync #(
        .N       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b110)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sclk, sdi}),
        .q     (pins_q)
    );

    sap_frame_ctrl #(
        .FRAME_LEN (FRAME_LEN),
        .HOLD_EDGE (HOLD_EDGE)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_q        (pins_q[2]),
        .sclk_q      (pins_q[1]),
        .frame_start (frame_start),
        .frame_stop  (frame_stop),
        .shift_en    (shift_en),
        .last_edge   (last_edge),
        .bit_cnt     (bit_cnt),
        .drive_en    (sdo_oe),
        .hold        (sample_hold)
    );

    sap_out_shift #(
        .TAG_W     (TAG_W),
        .RES_W     (RES_W),
        .FRAME_LEN (FRAME_LEN)
    ) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (frame_start),
        .shift (shift_en),
        .oe    (sdo_oe),
        .tag   (conv_tag),
        .res   (conv_result),
        .sdo   (sdo)
    );

    sap_ctl_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (frame_start),
        .shift     (shift_en),
        .last_edge (last_edge),
        .din       (pins_q[0]),
        .cfg       (cfg)
    );

    assign cfg_repeat   = cfg.rpt;
    assign cfg_chan_sel = cfg.chan;
    assign cfg_ref_sel  = cfg.ref_sel;
    assign cfg_pwr_down = cfg.pwr_dn;
endmodule

// File: rtl/sap_checker.sv
// Protocol checker for serial_adc_port, attached by bind below.
module sap_checker
    import sap_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             sdo,
    input logic             sdo_oe,
    input logic             sample_hold,
    input logic             tag_msb,
    input logic             frame_start,
    input logic             frame_stop,
    input logic [CNT_W-1:0] bit_cnt,
    input logic [CFG_W-1:0] cfg
);
    // R2: a frame start enables the pad, holds, and shows the tag MSB.
    p_start_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (sdo_oe && sample_hold && (sdo == $past(tag_msb))));

    // R4: hold is released no later than the pad is released.
    p_hold_within_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sample_hold |-> sdo_oe);

    // R5: a disabled pad reads zero.
    p_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> !sdo);

    // R6: an abort drops enable and hold in the next cycle.
    p_abort_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stop |=> (!sdo_oe && !sample_hold));

    // R7: configuration moves only at the end of a completed frame.
    p_cfg_commit_point_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg != $past(cfg)) |-> $fell(sdo_oe));

    // R10: each frame start restarts the edge count.
    p_count_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (bit_cnt == '0));

    // R11: a full count stays put until the next frame start.
    p_count_saturates_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((bit_cnt == CNT_W'(FRAME_LEN)) && !frame_start) |=> (bit_cnt == CNT_W'(FRAME_LEN)));

    // R11: the count never passes the frame length.
    always @(posedge clk) begin
        if (rst_n) begin
            p_count_bounded_r11: assert (bit_cnt <= CNT_W'(FRAME_LEN));
        end
    end
endmodule

bind serial_adc_port sap_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sdo         (sdo),
    .sdo_oe      (sdo_oe),
    .sample_hold (sample_hold),
    .tag_msb     (conv_tag[TAG_W-1]),
    .frame_start (frame_start),
    .frame_stop  (frame_stop),
    .bit_cnt     (bit_cnt),
    .cfg         (cfg)
);

// File: tb/tb_serial_adc_port.sv
module tb_serial_adc_port;
    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b1;
    logic       sdi = 1'b0;
    logic       sdo;
    logic       sdo_oe;
    logic       sample_hold;
    logic [3:0] conv_tag = '0;
    logic [9:0] conv_result = '0;
    logic       cfg_repeat;
    logic [7:0] cfg_chan_sel;
    logic       cfg_ref_sel;
    logic       cfg_pwr_down;

    int         n_checks = 0;
    int         n_fail = 0;
    logic [15:0] exp_cfg = '0;

    always #2.5 clk = ~clk;

    serial_adc_port dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .sample_hold(sample_hold),
        .conv_tag(conv_tag), .conv_result(conv_result),
        .cfg_repeat(cfg_repeat), .cfg_chan_sel(cfg_chan_sel),
        .cfg_ref_sel(cfg_ref_sel), .cfg_pwr_down(cfg_pwr_down)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R7/R8: configuration outputs against the bench model.
    task automatic check_cfg(input string req);
        check(req, {20'd0, cfg_repeat, cfg_chan_sel, cfg_ref_sel, cfg_pwr_down},
              {20'd0, exp_cfg[14], exp_cfg[13:6], exp_cfg[2], exp_cfg[0]});
    endtask

    // One frame: abort_after < 16 raises select early; extra adds clocks after 16.
    task automatic run_frame(input logic [3:0] tag, input logic [9:0] res,
                             input logic [15:0] cw, input int abort_after, input int extra);
        logic [15:0] word;
        word = {tag, res, 2'b00};
        conv_tag = tag;
        conv_result = res;
        sdi = cw[15];
        cs_n = 1'b0;
        wait_clk(HALF);
        check("R2 oe", 32'(sdo_oe), 32'd1);
        check("R2 hold", 32'(sample_hold), 32'd1);
        check("R3 first bit", 32'(sdo), 32'(word[15]));
        conv_tag = ~tag;          // R9: source changes mid-frame
        conv_result = ~res;
        for (int i = 1; i <= abort_after; i++) begin
            sclk = 1'b0;
            wait_clk(HALF);
            if (i < 16) begin
                check("R3 bit", {16'(i), 15'd0, sdo}, {16'(i), 15'd0, word[15-i]});
                check("R9 oe", 32'(sdo_oe), 32'd1);
            end else begin
                check("R5 oe off", 32'(sdo_oe), 32'd0);
                check("R5 sdo low", 32'(sdo), 32'd0);
            end
            check("R4 hold", {16'(i), 15'd0, sample_hold}, {16'(i), 15'd0, (i < 14)});
            sclk = 1'b1;
            if (i < 16) sdi = cw[15-i];
            wait_clk(HALF);
        end
        for (int e = 0; e < extra; e++) begin
            sdi = ~sdi;
            sclk = 1'b0;
            wait_clk(HALF);
            check("R11 oe stays off", 32'(sdo_oe), 32'd0);
            sclk = 1'b1;
            wait_clk(HALF);
        end
        cs_n = 1'b1;
        wait_clk(HALF);
        if (abort_after < 16) begin
            check("R6 oe off", 32'(sdo_oe), 32'd0);
            check("R6 hold off", 32'(sample_hold), 32'd0);
        end
        if (abort_after == 16 && cw[15]) exp_cfg = cw;
        if (abort_after < 16) check_cfg("R6 cfg kept");
        else if (extra > 0) check_cfg("R11 cfg");
        else if (cw[15]) check_cfg("R7 cfg");
        else check_cfg("R8 cfg kept");
        wait_clk(HALF);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        wait_clk(5);
        check("R1 oe", 32'(sdo_oe), 32'd0);
        check("R1 sdo", 32'(sdo), 32'd0);
        check("R1 hold", 32'(sample_hold), 32'd0);
        check_cfg("R1 cfg");
        rst_n = 1'b1;
        wait_clk(4);
        check("R1 oe after release", 32'(sdo_oe), 32'd0);

        // R3/R9: all tags against walking result patterns, no writes.
        for (int t = 0; t < 16; t++)
            for (int k = 0; k < 8; k++)
                run_frame(4'(t), 10'((1 << k) ^ (t * 73)), 16'h0000, 16, 0);

        // R7/R8: control words alternating write flag.
        for (int n = 0; n < 48; n++)
            run_frame(4'(n), 10'(n * 29), {n[0], 15'(n * 1237 + 3)}, 16, 0);

        // R6/R10: abort after every count, then a clean restart frame.
        for (int a = 0; a < 16; a++) begin
            run_frame(4'hA, 10'h2B5, 16'hFFFF ^ 16'(a), a, 0);
            run_frame(4'(a), 10'h3C3 ^ 10'(a), 16'h0000, 16, 0); // R10 restart
        end

        // R11: extra clocks after the sixteenth edge.
        for (int x = 0; x < 4; x++)
            run_frame(4'(x + 3), 10'h155, {1'b1, 15'(x * 4099 + 77)}, 16, 3);

        // R11: clocks while deselected change nothing.
        for (int y = 0; y < 6; y++) begin
            sdi = y[0];
            sclk = 1'b0;
            wait_clk(HALF);
            check("R11 idle oe", 32'(sdo_oe), 32'd0);
            check("R11 idle sdo", 32'(sdo), 32'd0);
            sclk = 1'b1;
            wait_clk(HALF);
        end
        check_cfg("R11 idle cfg");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule